// File: doc/BRIEF.md
# Serial EEPROM two-wire slave front end

This block sits between the two-wire serial bus pins of a byte-addressed non-volatile memory and that memory's storage and program sequencer. It oversamples the bus clock and data lines on a fast system clock and finds bus start and stop events. It shifts in a select byte and compares it with a fixed four-bit type code and three strap inputs. It acknowledges each accepted byte, and it collects a two-byte memory address, high byte first. It then either passes write data bytes to the sequencer or streams read bytes back to the bus master.

An internal address counter steps forward after every byte transferred and wraps at the top of the array. This gives sequential reads and current-address reads. A random read is a write header with no data, followed by a repeated start and a read select. While the sequencer reports a program cycle in progress, the block ignores bus start events. A stop that ends a write transaction with at least one data byte raises a single commit strobe for the sequencer.

Top module: `eep_i2c_slave`

## Requirements
- R1: A start event is the data line falling while the clock line is high. A stop event is the data line rising while the clock line is high. Outside a transaction (after reset, or after a stop), the block ignores bus traffic and acknowledges nothing until a start.
- R2: The byte after a start is taken MSB first. Bits 7:4 must equal the TYPE_CODE parameter (default 4'b1010), bits 3:1 must equal strap_i[2:0], and bit 0 selects read (1) or write (0). On a match, the block pulls the data line low during the ninth clock. On a mismatch, it leaves the line released and stays passive until the next start.
- R3: After a write select, two address bytes follow, high byte first, and each one is acknowledged. Only the low AW address bits are kept, so bits 15:13 are ignored for AW=13.
- R4: Each write data byte is acknowledged and passed on as exactly one wr_o pulse, with addr_o set to its target address and wdata_o set to its value. The address counter advances by one after each such pulse.
- R5: After a read select, the byte at the current address is shifted out MSB first. A master acknowledge (data line low on the ninth clock) fetches and sends the byte at the next address. A master no-acknowledge ends the read, and the block releases the line.
- R6: A random read (write select, two address bytes, repeated start, read select) returns data starting at the address just sent.
- R7: A current-address read returns the byte that follows the last byte written or read. The address wraps from 2^AW-1 to 0.
- R8: sda_pull_o changes only while the synchronized clock line is low. It is released during the master's acknowledge bit of a read.
- R9: While busy_i is high, a start event is ignored, so a select byte sent after it gets no acknowledge.
- R10: A stop that closes a write transaction carrying one or more data bytes produces one commit_o pulse. A transaction without data bytes, including the header of a random read, produces none.
- R11: During and right after reset, sda_pull_o, wr_o, rd_o and commit_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bus clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| strap_i | input | 3 | Board-strapped select bits, compared with select byte bits 3:1 |
| busy_i | input | 1 | Program cycle in progress; bus starts are ignored |
| wr_o | output | 1 | One-cycle strobe for a received write data byte |
| rd_o | output | 1 | One-cycle read request; rdata_i is expected one cycle later |
| addr_o | output | AW | Address counter, valid with wr_o and rd_o |
| wdata_o | output | 8 | Write data byte, valid with wr_o |
| rdata_i | input | 8 | Read data from storage, one cycle after rd_o |
| commit_o | output | 1 | One-cycle strobe: program the written bytes |

## Verification
The bench writes bursts that cross the top of the array. A counter that did not wrap, or that kept the ignored high address bits, would read back the wrong bytes. It issues current-address reads after writes, after random reads and after rejected selects. A pointer that advanced one byte too far or too short, or that moved on a rejected transaction, shows up as a data mismatch there. Wrong type codes and strap values, a select byte sent with no start, and a start during a program cycle must all go unacknowledged. Random reads must raise no commit, and a slave that still held the line during the master's no-acknowledge bit would be seen on the wire.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } state_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BITS_PER_BYTE = 8;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s_o    = scl_pipe[SYNC_STAGES-1];
  assign sda_s_o    = sda_pipe[SYNC_STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  // data edge while clock held high on both samples
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/eep_shift.sv
module eep_shift
  import eep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              sda_i,
  input  logic              load_en_i,
  input  logic [BYTE_W-1:0] load_i,
  input  logic [2:0]        idx_i,
  output logic [BYTE_W-1:0] rx_o,
  output logic              tx_bit_o
);
  logic [BYTE_W-1:0] rx_q, tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
      tx_q <= '1;
    end else begin
      if (shift_en_i) rx_q <= {rx_q[BYTE_W-2:0], sda_i};
      if (load_en_i)  tx_q <= load_i;
    end
  end

  assign rx_o     = rx_q;
  assign tx_bit_o = tx_q[3'd7 - idx_i];
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int unsigned AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [15:0]   load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_val_i[AW-1:0];
    else if (inc_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int unsigned AW        = 13,
  parameter logic [3:0]  TYPE_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              wr_o,
  output logic              rd_o,
  output logic [AW-1:0]     addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              commit_o
);
  localparam logic [3:0] LAST_CNT = 4'(BITS_PER_BYTE);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rx_byte;
  logic tx_bit, shift_en, addr_ld, rd_vld_q;
  logic [2:0] tx_idx;

  state_e state_q, state_d;
  logic [3:0] bit_cnt_q, bit_cnt_d;
  logic ack_ph_q, ack_ph_d;
  logic pull_q, pull_d;
  logic wpend_q, wpend_d;
  logic mack_q, mack_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic wr_q, wr_d, rd_q, rd_d, commit_q, commit_d;

  eep_bus_sync #(.SYNC_STAGES(2)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  assign tx_idx = ack_ph_q ? 3'd0 : bit_cnt_q[2:0];

  eep_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .sda_i      (sda_s),
    .load_en_i  (rd_vld_q),
    .load_i     (rdata_i),
    .idx_i      (tx_idx),
    .rx_o       (rx_byte),
    .tx_bit_o   (tx_bit)
  );

  eep_addr_ctr #(.AW(AW)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_ld),
    .load_val_i ({hi_q, rx_byte}),
    .inc_i      (wr_q | rd_q),
    .addr_o     (addr_o)
  );

  always_comb begin
    state_d   = state_q;
    bit_cnt_d = bit_cnt_q;
    ack_ph_d  = ack_ph_q;
    pull_d    = pull_q;
    wpend_d   = wpend_q;
    mack_d    = mack_q;
    hi_d      = hi_q;
    wr_d      = 1'b0;
    rd_d      = 1'b0;
    commit_d  = 1'b0;
    shift_en  = 1'b0;
    addr_ld   = 1'b0;
    if (stop_det) begin
      state_d  = ST_IDLE;
      pull_d   = 1'b0;
      commit_d = wpend_q;
      wpend_d  = 1'b0;
    end else if (start_det && !busy_i) begin
      state_d   = ST_DEV;
      bit_cnt_d = '0;
      ack_ph_d  = 1'b0;
      pull_d    = 1'b0;
      wpend_d   = 1'b0;
    end else if (state_q == ST_RDAT) begin
      if (!ack_ph_q) begin
        if (scl_rise && bit_cnt_q < LAST_CNT) begin
          bit_cnt_d = bit_cnt_q + 4'd1;
        end else if (scl_fall) begin
          if (bit_cnt_q == LAST_CNT) begin
            pull_d   = 1'b0;   // master drives its acknowledge
            ack_ph_d = 1'b1;
          end else begin
            pull_d = ~tx_bit;
          end
        end
      end else begin
        if (scl_rise) begin
          mack_d = ~sda_s;
          rd_d   = ~sda_s;     // prefetch next byte only if acked
        end else if (scl_fall) begin
          ack_ph_d  = 1'b0;
          bit_cnt_d = '0;
          if (mack_q) pull_d = ~tx_bit;
          else        state_d = ST_IDLE;
        end
      end
    end else if (state_q != ST_IDLE) begin
      if (!ack_ph_q) begin
        if (scl_rise && bit_cnt_q < LAST_CNT) begin
          shift_en  = 1'b1;
          bit_cnt_d = bit_cnt_q + 4'd1;
        end else if (scl_fall && bit_cnt_q == LAST_CNT) begin
          case (state_q)
            ST_DEV: begin
              if (rx_byte[7:1] == {TYPE_CODE, strap_i}) begin
                pull_d   = 1'b1;
                ack_ph_d = 1'b1;
                rd_d     = rx_byte[0];
              end else begin
                state_d = ST_IDLE;
              end
            end
            ST_AHI: begin
              hi_d     = rx_byte;
              pull_d   = 1'b1;
              ack_ph_d = 1'b1;
            end
            ST_ALO: begin
              addr_ld  = 1'b1;
              pull_d   = 1'b1;
              ack_ph_d = 1'b1;
            end
            default: begin
              wr_d     = 1'b1;
              wpend_d  = 1'b1;
              pull_d   = 1'b1;
              ack_ph_d = 1'b1;
            end
          endcase
        end
      end else if (scl_fall) begin
        ack_ph_d  = 1'b0;
        bit_cnt_d = '0;
        pull_d    = 1'b0;
        case (state_q)
          ST_DEV: begin
            if (rx_byte[0]) begin
              state_d = ST_RDAT;
              pull_d  = ~tx_bit;
            end else begin
              state_d = ST_AHI;
            end
          end
          ST_AHI:  state_d = ST_ALO;
          default: state_d = ST_WDAT;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      pull_q    <= 1'b0;
      wpend_q   <= 1'b0;
      mack_q    <= 1'b0;
      hi_q      <= '0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      commit_q  <= 1'b0;
      rd_vld_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      bit_cnt_q <= bit_cnt_d;
      ack_ph_q  <= ack_ph_d;
      pull_q    <= pull_d;
      wpend_q   <= wpend_d;
      mack_q    <= mack_d;
      hi_q      <= hi_d;
      wr_q      <= wr_d;
      rd_q      <= rd_d;
      commit_q  <= commit_d;
      rd_vld_q  <= rd_q;
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_o       = wr_q;
  assign rd_o       = rd_q;
  assign commit_o   = commit_q;
  assign wdata_o    = rx_byte;
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk
  import eep_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          stop_det,
  input logic          busy_i,
  input state_e        state_q,
  input logic          sda_pull_o,
  input logic          wr_o,
  input logic          rd_o,
  input logic          commit_o,
  input logic [AW-1:0] addr_o
);
  assert_pull_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !scl_s);

  assert_idle_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_pull_o);

  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && state_q == ST_IDLE) |=> (state_q == ST_IDLE));

  assert_wr_acked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (sda_pull_o && !rd_o));

  assert_addr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o || rd_o) |=> (addr_o == AW'($past(addr_o) + 1'b1)));

  assert_commit_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_det));
endmodule

bind eep_i2c_slave eep_i2c_slave_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .stop_det   (stop_det),
  .busy_i     (busy_i),
  .state_q    (state_q),
  .sda_pull_o (sda_pull_o),
  .wr_o       (wr_o),
  .rd_o       (rd_o),
  .commit_o   (commit_o),
  .addr_o     (addr_o)
);

// File: tb/tb_eep_i2c_slave.sv
module tb_eep_i2c_slave;
  localparam int AW = 13;
  localparam int AMASK = (1 << AW) - 1;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic busy = 1'b0;
  logic sda_pull, wr, rd, commit;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata;
  logic sda_bus;

  int n_chk = 0, n_fail = 0, n_commit = 0;
  logic [7:0] st_mem [int];
  logic [7:0] exp_mem [int];
  int exp_ptr = 0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  eep_i2c_slave #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .strap_i(STRAP), .busy_i(busy),
    .wr_o(wr), .rd_o(rd), .addr_o(addr), .wdata_o(wdata),
    .rdata_i(rdata), .commit_o(commit)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'(a) ^ 8'((a >> 8) * 37);
  endfunction

  // storage model: one-cycle read latency
  always @(posedge clk) begin
    if (wr) st_mem[int'(addr)] = wdata;
    if (rd) rdata <= st_mem.exists(int'(addr)) ? st_mem[int'(addr)] : init_val(int'(addr));
  end

  always @(negedge clk) if (commit) n_commit++;

  function automatic logic [7:0] exp_rd(int a);
    int m = a & AMASK;
    return exp_mem.exists(m) ? exp_mem[m] : init_val(m);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic smp);
    wt(5); sda_m = b; wt(5); scl_m = 1'b1; wt(5); smp = sda_bus; wt(5); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    wt(5); sda_m = 1'b1; wt(5); scl_m = 1'b1; wt(10); sda_m = 1'b0; wt(10); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wt(5); sda_m = 1'b0; wt(5); scl_m = 1'b1; wt(10); sda_m = 1'b1; wt(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    put_bit(1'b1, s);
    ack = (s == 1'b0);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, s);
      v[i] = s;
    end
    put_bit(mack ? 1'b0 : 1'b1, s);
    if (!mack) chk(s == 1'b1, "R8 released in master ack bit", int'(s), 1);
  endtask

  function automatic logic [7:0] dev(input bit rdb);
    return {4'b1010, STRAP, rdb};
  endfunction

  task automatic do_write(input int a16, input int n, input bit rnd, input logic [7:0] seed_b);
    bit ack;
    int c0 = n_commit;
    int a = a16 & AMASK;
    logic [7:0] d;
    bus_start();
    send_byte(dev(1'b0), ack); chk(ack, "R2 write select ack", int'(ack), 1);
    send_byte(8'(a16 >> 8), ack); chk(ack, "R3 high address ack", int'(ack), 1);
    send_byte(8'(a16), ack); chk(ack, "R3 low address ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      d = rnd ? 8'($urandom) : seed_b + 8'(i);
      send_byte(d, ack); chk(ack, "R4 data ack", int'(ack), 1);
      exp_mem[a] = d;
      a = (a + 1) & AMASK;
    end
    bus_stop();
    wt(6);
    exp_ptr = a;
    chk(n_commit == c0 + (n > 0 ? 1 : 0), "R10 commit count", n_commit - c0, n > 0 ? 1 : 0);
  endtask

  task automatic read_body(input int n, input string tag);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      chk(v == exp_rd(exp_ptr), tag, int'(v), int'(exp_rd(exp_ptr)));
      exp_ptr = (exp_ptr + 1) & AMASK;
    end
    bus_stop();
    wt(6);
  endtask

  task automatic do_rand_read(input int a16, input int n);
    bit ack;
    int c0 = n_commit;
    bus_start();
    send_byte(dev(1'b0), ack); chk(ack, "R6 dummy write select ack", int'(ack), 1);
    send_byte(8'(a16 >> 8), ack); chk(ack, "R3 high address ack", int'(ack), 1);
    send_byte(8'(a16), ack); chk(ack, "R3 low address ack", int'(ack), 1);
    bus_start();
    send_byte(dev(1'b1), ack); chk(ack, "R6 read select ack", int'(ack), 1);
    exp_ptr = a16 & AMASK;
    read_body(n, "R5 R6 random read data");
    chk(n_commit == c0, "R10 no commit for random read", n_commit - c0, 0);
  endtask

  task automatic do_cur_read(input int n);
    bit ack;
    bus_start();
    send_byte(dev(1'b1), ack); chk(ack, "R7 current read select ack", int'(ack), 1);
    read_body(n, "R7 current address data");
  endtask

  task automatic bad_select(input logic [7:0] code, input string tag);
    bit ack;
    bus_start();
    send_byte(code, ack);
    chk(!ack, tag, int'(ack), 0);
    bus_stop();
    wt(6);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    void'($urandom(32'h1D5));
    wt(4);
    chk(sda_pull == 1'b0 && wr == 1'b0 && rd == 1'b0 && commit == 1'b0,
        "R11 outputs in reset", {sda_pull, wr, rd, commit}, 0);
    rst_n = 1'b1;
    wt(10);
    chk(sda_pull == 1'b0 && wr == 1'b0 && rd == 1'b0 && commit == 1'b0,
        "R11 outputs after reset", {sda_pull, wr, rd, commit}, 0);

    // R1: select byte without a start is ignored
    scl_m = 1'b0; wt(5);
    send_byte(dev(1'b0), ack);
    chk(!ack, "R1 no ack without start", int'(ack), 0);
    bus_stop(); wt(6);

    do_write(16'h0123, 3, 1'b0, 8'hA0);
    do_rand_read(16'h0123, 3);
    do_cur_read(2);

    // wrap and ignored high bits (R3, R7)
    do_write(16'hFFFE, 4, 1'b0, 8'h30);
    do_rand_read(16'h1FFE, 4);
    do_cur_read(1);

    // header-only write moves the pointer but does not commit (R10)
    do_write(16'h0400, 0, 1'b0, 8'h00);
    do_cur_read(1);

    bad_select({4'b1010, STRAP ^ 3'b001, 1'b1}, "R2 strap mismatch no ack");
    bad_select({4'b1011, STRAP, 1'b1}, "R2 type mismatch no ack");
    bad_select({4'b0010, STRAP, 1'b0}, "R2 type mismatch write no ack");
    do_cur_read(1);

    busy = 1'b1;
    bad_select(dev(1'b1), "R9 start ignored while busy");
    busy = 1'b0;
    do_cur_read(1);

    for (int k = 0; k < 24; k++) begin
      int op = $urandom_range(0, 2);
      int a = ($urandom_range(0, 3) == 0) ? (AMASK - $urandom_range(0, 3)) : $urandom_range(0, 65535);
      if (op == 0)      do_write(a, $urandom_range(1, 5), 1'b1, 8'h00);
      else if (op == 1) do_rand_read(a, $urandom_range(1, 5));
      else              do_cur_read($urandom_range(1, 4));
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule